// File: doc/BRIEF.md
# Three-Stage In-Order Execution Pipeline

This block is a small in-order processor core built as three stages. The first stage puts a fetch address on the instruction-memory port. The second stage takes the word that memory returns one cycle later and decodes it. The third stage reads the register file, runs the single shared ALU and commits the result. The core knows five kinds of instruction: register operations, loads, stores, an unconditional jump that also writes a link register, and a conditional branch on equality. It also treats every other opcode as an empty slot.

Loads and stores talk to a separate load/store unit through a request pulse and a later acknowledge or error. Execute waits on that unit for as long as needed, and the two front stages freeze while it waits. A taken jump starts fetching its target in the same cycle, which costs exactly one squashed slot. If a memory access reports an error, the core discards the faulting instruction and the one behind it and fetches from a fixed exception address. A writeback trace port shows every register-file write.

Top module: `pipe3_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `imem_addr` equals `RESET_PC`, `wb_en` is 0 and `lsu_req` is 0.
- R2: Instruction memory returns the word for an address one cycle after it is presented. With no stall or redirect, `imem_addr` rises by 4 each cycle, and a fetched instruction executes two cycles after its address was presented.
- R3: Instruction word format: [31:28] class (0 register op, 1 load, 2 store, 3 jump-and-link, 4 branch-if-equal, any other value no operation), [27:24] rd, [23:20] rs0, [19:16] rs1, [15:0] signed immediate. For a register op, bits [2:0] pick the function: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right logical, 7 signed less-than (result 1 or 0). The function acts on rs0 and rs1, and the result is written to rd in the single execute cycle.
- R4: Register 0 always reads zero. An instruction whose rd is 0 never raises `wb_en`.
- R5: A load raises `lsu_req` for exactly one cycle, with `lsu_we`=0 and `lsu_addr` = rs0 + immediate. In the cycle `lsu_ack` arrives, whether one or many cycles later, it writes `lsu_rdata` to rd.
- R6: A store raises `lsu_req` with `lsu_we`=1, `lsu_addr` = rs0 + immediate and `lsu_wdata` = rs1. It writes no register.
- R7: From the request cycle until acknowledge or error, `imem_addr` holds its value and no later instruction executes.
- R8: A jump-and-link sets the next fetch address to rs0 + immediate in its execute cycle and writes its own address + 4 to rd. The instruction behind it never executes, so exactly one slot is lost.
- R9: A branch-if-equal with rs0 == rs1 fetches address + immediate in its execute cycle and squashes the instruction behind it. When rs0 != rs1, fetch continues in sequence with no lost slot.
- R10: When `lsu_err` is seen during a wait, `imem_addr` equals `EXC_ENTRY` in that cycle. Neither the faulting load nor the instruction behind it writes a register, and the first instruction at `EXC_ENTRY` executes two cycles later. Error takes priority over a simultaneous acknowledge.
- R11: A no-operation class, or an empty slot, writes no register and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word for the previous cycle's address |
| lsu_req | output | 1 | Memory request pulse |
| lsu_we | output | 1 | 1 for store, 0 for load |
| lsu_addr | output | 32 | Memory address computed by the ALU |
| lsu_wdata | output | 32 | Store data |
| lsu_ack | input | 1 | Access completed successfully |
| lsu_err | input | 1 | Access failed |
| lsu_rdata | input | 32 | Load data, valid with `lsu_ack` |
| wb_en | output | 1 | Register-file write this cycle |
| wb_idx | output | 4 | Register written |
| wb_data | output | 32 | Value written |

## Verification
The bench builds the core with `RESET_PC` = 0 and `EXC_ENTRY` = 0x80. With these values both the main program and the exception handler sit in a 64-word instruction model, so a single run covers the fault path and the return to normal execution. The load/store model sets each access's latency from address bits [4:2], which gives waits of two to five cycles. It reports an error for address 0xF0. Together these produce stalls of several lengths, a store followed by a reload, and a fault whose shadow instruction must be discarded.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    localparam int XLEN  = 32;
    localparam int RIDX  = 4;
    localparam int NREGS = 1 << RIDX;

    typedef enum logic [3:0] {
        CL_OP  = 4'd0,
        CL_LD  = 4'd1,
        CL_ST  = 4'd2,
        CL_JAL = 4'd3,
        CL_BEQ = 4'd4,
        CL_NOP = 4'd15
    } cls_e;

    typedef enum logic [2:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLL, FN_SRL, FN_SLT
    } fn_e;

    typedef struct packed {
        logic            valid;
        cls_e            cls;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs0;
        logic [RIDX-1:0] rs1;
        fn_e             fn;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] pc;
    } exop_s;

    function automatic exop_s decode(input logic [XLEN-1:0] w,
                                     input logic            v,
                                     input logic [XLEN-1:0] pc);
        exop_s o;
        o.valid = v;
        case (w[31:28])
            4'd0:    o.cls = CL_OP;
            4'd1:    o.cls = CL_LD;
            4'd2:    o.cls = CL_ST;
            4'd3:    o.cls = CL_JAL;
            4'd4:    o.cls = CL_BEQ;
            default: o.cls = CL_NOP;
        endcase
        o.rd  = w[27:24];
        o.rs0 = w[23:20];
        o.rs1 = w[19:16];
        o.fn  = fn_e'(w[2:0]);
        o.imm = {{(XLEN-16){w[15]}}, w[15:0]};
        o.pc  = pc;
        return o;
    endfunction

endpackage

// File: rtl/p3_alu.sv
module p3_alu import pipe3_pkg::*; #(
    parameter int W = 32
) (
    input  fn_e          fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SH = $clog2(W);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SLL:  y = a << b[SH-1:0];
            FN_SRL:  y = a >> b[SH-1:0];
            default: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
    end
endmodule

// File: rtl/p3_fetch.sv
module p3_fetch #(
    parameter int           W        = 32,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  logic         redirect,
    input  logic [W-1:0] target,
    output logic [W-1:0] fetch_addr,
    output logic [W-1:0] d_pc,
    output logic         d_valid
);
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] pc_q;

    // Redirect wins; a stall re-presents the held decode address so that the
    // synchronous memory keeps returning the same word.
    always_comb begin
        if (redirect)   fetch_addr = target;
        else if (stall) fetch_addr = d_pc;
        else            fetch_addr = pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            d_pc    <= RESET_PC;
            d_valid <= 1'b0;
        end else begin
            d_pc    <= fetch_addr;
            d_valid <= 1'b1;
            if (!stall) pc_q <= fetch_addr + STEP;
        end
    end
endmodule

// File: rtl/p3_regfile.sv
module p3_regfile #(
    parameter int W    = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [NREG-1:0][W-1:0] regs;

    assign regs[0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                        q <= '0;
            else if (we && wa == AW'(i))    q <= wd;
        end
        assign regs[i] = q;
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core import pipe3_pkg::*; #(
    parameter logic [XLEN-1:0] RESET_PC  = '0,
    parameter logic [XLEN-1:0] EXC_ENTRY = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic            lsu_req,
    output logic            lsu_we,
    output logic [XLEN-1:0] lsu_addr,
    output logic [XLEN-1:0] lsu_wdata,
    input  logic            lsu_ack,
    input  logic            lsu_err,
    input  logic [XLEN-1:0] lsu_rdata,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data
);
    exop_s           ex_q;
    logic            ex_wait;
    logic            ex_vld;
    logic [XLEN-1:0] d_pc;
    logic            d_valid;
    logic [XLEN-1:0] rs0_v, rs1_v;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    fn_e             alu_fn;
    logic            is_mem, fault, stall, jmp_taken, redirect;
    logic [XLEN-1:0] target;
    logic            wb_cand;

    assign ex_vld = ex_q.valid;

    // ---------------- front end ----------------
    p3_fetch #(.W(XLEN), .RESET_PC(RESET_PC)) fetch_i (
        .clk(clk), .rst(rst), .stall(stall), .redirect(redirect),
        .target(target), .fetch_addr(imem_addr), .d_pc(d_pc), .d_valid(d_valid)
    );

    // ---------------- register file ----------------
    p3_regfile #(.W(XLEN), .NREG(NREGS)) rf_i (
        .clk(clk), .rst(rst), .ra0(ex_q.rs0), .ra1(ex_q.rs1),
        .rd0(rs0_v), .rd1(rs1_v), .we(wb_en), .wa(wb_idx), .wd(wb_data)
    );

    // ---------------- shared ALU ----------------
    always_comb begin
        alu_a  = rs0_v;
        alu_b  = ex_q.imm;
        alu_fn = FN_ADD;
        case (ex_q.cls)
            CL_OP:   begin alu_b = rs1_v; alu_fn = ex_q.fn; end
            CL_BEQ:  alu_a = ex_q.pc;
            default: ;
        endcase
    end

    p3_alu #(.W(XLEN)) alu_i (.fn(alu_fn), .a(alu_a), .b(alu_b), .y(alu_y));

    // ---------------- execute control ----------------
    assign is_mem    = ex_q.valid && (ex_q.cls == CL_LD || ex_q.cls == CL_ST);
    assign fault     = ex_wait && lsu_err;
    assign stall     = is_mem && !(ex_wait && (lsu_ack || lsu_err));
    assign jmp_taken = ex_q.valid && (ex_q.cls == CL_JAL ||
                                      (ex_q.cls == CL_BEQ && rs0_v == rs1_v));
    assign redirect  = jmp_taken || fault;
    assign target    = fault ? EXC_ENTRY : alu_y;

    assign lsu_req   = is_mem && !ex_wait;
    assign lsu_we    = (ex_q.cls == CL_ST);
    assign lsu_addr  = alu_y;
    assign lsu_wdata = rs1_v;

    always_comb begin
        wb_cand = 1'b0;
        wb_data = alu_y;
        if (ex_q.valid) begin
            case (ex_q.cls)
                CL_OP:  wb_cand = 1'b1;
                CL_JAL: begin wb_cand = 1'b1; wb_data = ex_q.pc + XLEN'(4); end
                CL_LD:  begin wb_cand = ex_wait && lsu_ack && !lsu_err;
                              wb_data = lsu_rdata; end
                default: ;
            endcase
        end
    end
    assign wb_en  = wb_cand && (ex_q.rd != '0);
    assign wb_idx = ex_q.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q    <= '0;
            ex_wait <= 1'b0;
        end else if (redirect) begin
            ex_q.valid <= 1'b0;
            ex_wait    <= 1'b0;
        end else if (stall) begin
            if (lsu_req) ex_wait <= 1'b1;
        end else begin
            ex_q    <= decode(imem_rdata, d_valid, d_pc);
            ex_wait <= 1'b0;
        end
    end
endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk #(
    parameter logic [31:0] EXC_ENTRY = 32'h0000_0100
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic        lsu_req,
    input logic        lsu_ack,
    input logic        lsu_err,
    input logic        wb_en,
    input logic        ex_wait,
    input logic        ex_vld,
    input logic        jmp_taken
);
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        lsu_req |=> !lsu_req);

    p_hold_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        (ex_wait && !lsu_ack && !lsu_err) |-> $stable(imem_addr));

    p_fault_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (ex_wait && lsu_err) |-> (imem_addr == EXC_ENTRY && !wb_en));

    p_fault_shadow_r10: assert property (@(posedge clk) disable iff (rst)
        (ex_wait && lsu_err) |=> (!wb_en && !lsu_req));

    p_squash_r8: assert property (@(posedge clk) disable iff (rst)
        jmp_taken |=> !ex_vld);

    p_empty_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ex_vld |-> (!wb_en && !lsu_req));
endmodule

bind pipe3_core pipe3_core_chk #(.EXC_ENTRY(EXC_ENTRY)) chk_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .lsu_req(lsu_req),
    .lsu_ack(lsu_ack), .lsu_err(lsu_err), .wb_en(wb_en), .ex_wait(ex_wait),
    .ex_vld(ex_vld), .jmp_taken(jmp_taken)
);

// File: tb/pipe3_core_tb_top.sv
module pipe3_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic        lsu_req, lsu_we, lsu_ack, lsu_err;
    logic [31:0] lsu_addr, lsu_wdata, lsu_rdata;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;

    always #2 clk = ~clk;   // 250 MHz

    pipe3_core #(.RESET_PC(32'h0), .EXC_ENTRY(32'h80)) dut_i (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .lsu_req(lsu_req), .lsu_we(lsu_we), .lsu_addr(lsu_addr),
        .lsu_wdata(lsu_wdata), .lsu_ack(lsu_ack), .lsu_err(lsu_err),
        .lsu_rdata(lsu_rdata), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory models ----------------
    logic [31:0] imem [64];
    logic [31:0] dmem [16];
    int          lcnt;
    logic        l_err_pend;

    always_ff @(posedge clk) imem_rdata <= imem[imem_addr[7:2]];

    always_ff @(posedge clk) begin
        if (rst) begin
            lsu_ack <= 0; lsu_err <= 0; lsu_rdata <= '0; lcnt <= 0; l_err_pend <= 0;
        end else begin
            lsu_ack <= 0; lsu_err <= 0;
            if (lsu_req) begin
                l_err_pend <= (lsu_addr[7:0] == 8'hF0);
                if (lsu_we) dmem[lsu_addr[5:2]] <= lsu_wdata;
                lsu_rdata <= dmem[lsu_addr[5:2]];
                lcnt <= {29'd0, lsu_addr[4:2]};   // latency = 1 + addr[4:2]
                if (lsu_addr[4:2] == 3'd0) begin
                    if (lsu_addr[7:0] == 8'hF0) lsu_err <= 1; else lsu_ack <= 1;
                end
            end else if (lcnt != 0) begin
                lcnt <= lcnt - 1;
                if (lcnt == 1) begin
                    if (l_err_pend) lsu_err <= 1; else lsu_ack <= 1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [35:0] wb_q[$];
    string       wb_tag[$];
    logic [64:0] rq_q[$];
    string       rq_tag[$];
    logic [31:0] trace[$];
    int          cyc = 0;
    int          wcyc[16];
    int          wcnt[16];
    int          err_cyc = -1;
    int          r0_hits = 0;
    bit          mon_on = 0;

    task automatic exp_wb(input logic [3:0] idx, input logic [31:0] v, input string t);
        wb_q.push_back({idx, v}); wb_tag.push_back(t);
    endtask
    task automatic exp_rq(input bit we, input logic [31:0] a, input logic [31:0] d, input string t);
        rq_q.push_back({we, a, d}); rq_tag.push_back(t);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            trace.push_back(imem_addr);
            if (wb_en) begin
                if (wb_idx == 4'd0) r0_hits++;
                wcyc[wb_idx] = cyc;
                wcnt[wb_idx]++;
                if (wb_q.size() == 0)
                    chk(0, "R11", "unexpected write", {28'd0, wb_idx}, 32'hFFFF_FFFF);
                else begin
                    logic [35:0] e;
                    string t;
                    e = wb_q.pop_front(); t = wb_tag.pop_front();
                    chk(wb_idx == e[35:32], t, "write index", {28'd0, wb_idx}, {28'd0, e[35:32]});
                    chk(wb_data == e[31:0], t, "write data", wb_data, e[31:0]);
                end
            end
            if (lsu_req) begin
                if (rq_q.size() == 0)
                    chk(0, "R11", "unexpected request", lsu_addr, 32'hFFFF_FFFF);
                else begin
                    logic [64:0] r;
                    string t;
                    r = rq_q.pop_front(); t = rq_tag.pop_front();
                    chk(lsu_we == r[64], t, "direction", {31'd0, lsu_we}, {31'd0, r[64]});
                    chk(lsu_addr == r[63:32], t, "address", lsu_addr, r[63:32]);
                    if (r[64]) chk(lsu_wdata == r[31:0], t, "store data", lsu_wdata, r[31:0]);
                end
            end
            if (lsu_err) begin
                err_cyc = cyc;
                chk(imem_addr == 32'h80, "R10", "fetch at fault", imem_addr, 32'h80);
                chk(!wb_en, "R10", "no write at fault", {31'd0, wb_en}, 32'd0);
            end
            cyc++;
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] c, input logic [3:0] rd,
                                        input logic [3:0] a, input logic [3:0] b,
                                        input logic [15:0] imm);
        return {c, rd, a, b, imm};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- driver ----------------
    initial begin
        int idx2c;
        int n4c;
        int guard;
        logic [31:0] head [9];
        logic [31:0] pat  [7];

        for (int i = 0; i < 64; i++) imem[i] = 32'hF000_0000;
        for (int i = 0; i < 16; i++) dmem[i] = 32'h1000 + i;
        for (int i = 0; i < 16; i++) begin wcyc[i] = -1; wcnt[i] = 0; end

        imem[0]  = enc(1, 1, 0, 0, 16'h0004);   // ld  r1,[4]
        imem[1]  = enc(1, 2, 0, 0, 16'h0008);   // ld  r2,[8]
        imem[2]  = enc(0, 3, 1, 2, 16'd0);      // add
        imem[3]  = enc(0, 4, 2, 1, 16'd1);      // sub
        imem[4]  = enc(0, 5, 1, 2, 16'd4);      // xor
        imem[5]  = enc(0, 6, 4, 3, 16'd7);      // slt
        imem[6]  = enc(0, 7, 1, 4, 16'd5);      // sll
        imem[7]  = enc(0, 0, 1, 2, 16'd0);      // add to r0
        imem[8]  = enc(2, 0, 0, 3, 16'h000C);   // st  [12]=r3
        imem[9]  = enc(1, 8, 0, 0, 16'h000C);   // ld  r8,[12]
        imem[10] = enc(4, 0, 1, 2, 16'h0040);   // beq not taken
        imem[11] = enc(4, 0, 4, 6, 16'h0008);   // beq taken -> 0x34
        imem[12] = enc(0, 9, 1, 1, 16'd0);      // squashed
        imem[13] = enc(3, 10, 0, 0, 16'h0040);  // jal r10 -> 0x40
        imem[14] = enc(0, 11, 1, 1, 16'd0);     // squashed
        imem[16] = enc(15, 12, 1, 1, 16'd0);    // no-op class
        imem[17] = enc(0, 12, 3, 1, 16'd2);     // and
        imem[18] = enc(1, 13, 0, 0, 16'h00F0);  // faulting load
        imem[19] = enc(0, 14, 1, 1, 16'd0);     // fault shadow
        imem[32] = enc(0, 14, 1, 2, 16'd3);     // or  (handler)
        imem[33] = enc(0, 15, 3, 4, 16'd6);     // srl
        imem[34] = enc(3, 0, 0, 0, 16'h0088);   // jal r0 self loop

        exp_rq(0, 32'h4, 0, "R5");          exp_wb(1, 32'h1001, "R5");
        exp_rq(0, 32'h8, 0, "R5");          exp_wb(2, 32'h1002, "R5");
        exp_wb(3, 32'h2003, "R3");          exp_wb(4, 32'h1, "R3");
        exp_wb(5, 32'h3, "R3");             exp_wb(6, 32'h1, "R3");
        exp_wb(7, 32'h2002, "R3");
        exp_rq(1, 32'hC, 32'h2003, "R6");
        exp_rq(0, 32'hC, 0, "R6");          exp_wb(8, 32'h2003, "R6");
        exp_wb(10, 32'h38, "R8");           exp_wb(12, 32'h1, "R11");
        exp_rq(0, 32'hF0, 0, "R10");
        exp_wb(14, 32'h1003, "R10");        exp_wb(15, 32'h1001, "R3");

        // R1: reset state
        repeat (2) @(negedge clk);
        chk(imem_addr == 32'h0, "R1", "fetch in reset", imem_addr, 32'h0);
        chk(!wb_en && !lsu_req, "R1", "quiet in reset", {30'd0, wb_en, lsu_req}, 32'd0);
        @(posedge clk); #1 rst = 0; mon_on = 1;

        guard = 0;
        while ((wb_q.size() != 0 || rq_q.size() != 0) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (20) @(negedge clk);
        #1;

        // R1/R2/R5/R7: opening fetch sequence with two stalled loads
        head = '{32'h0, 32'h4, 32'h4, 32'h4, 32'h8, 32'h8, 32'h8, 32'h8, 32'hC};
        for (int i = 0; i < 9; i++)
            chk(trace[i] == head[i], (i == 0) ? "R1" : "R7", "opening fetch", trace[i], head[i]);

        // R2/R3: register ops follow each other one per cycle
        chk(wcyc[3] - wcyc[2] == 1, "R2", "op after load gap", wcyc[3] - wcyc[2], 1);
        chk(wcyc[4] - wcyc[3] == 1, "R3", "op single cycle", wcyc[4] - wcyc[3], 1);

        // R8/R9: fetch pattern around branches and jump
        pat = '{32'h28, 32'h2C, 32'h30, 32'h34, 32'h38, 32'h40, 32'h44};
        idx2c = -1;
        for (int i = 1; i < trace.size(); i++)
            if (idx2c < 0 && trace[i] == 32'h2C) idx2c = i;
        for (int k = 0; k < 7; k++) begin
            logic [31:0] got;
            got = (idx2c >= 1 && idx2c - 1 + k < trace.size()) ? trace[idx2c - 1 + k] : 32'hDEAD;
            chk(got == pat[k], (k < 3) ? "R9" : "R8", "redirect fetch", got, pat[k]);
        end
        chk(wcnt[9] == 0, "R9", "branch shadow writes", wcnt[9], 0);
        chk(wcnt[11] == 0, "R8", "jump shadow writes", wcnt[11], 0);

        // R7/R10: fault wait and handler timing
        n4c = 0;
        foreach (trace[i]) if (trace[i] == 32'h4C) n4c++;
        chk(n4c == 6, "R7", "held fetch during wait", n4c, 6);
        chk(wcnt[13] == 0, "R10", "faulting load writes", wcnt[13], 0);
        chk(wcnt[14] == 1, "R10", "shadow of fault writes", wcnt[14], 1);
        chk(wcyc[14] - err_cyc == 2, "R10", "handler latency", wcyc[14] - err_cyc, 2);

        // R4/R11
        chk(r0_hits == 0, "R4", "writes to register 0", r0_hits, 0);
        chk(wcnt[12] == 1, "R11", "no-op class writes", wcnt[12], 1);
        chk(wb_q.size() == 0 && rq_q.size() == 0, "R5", "scoreboard drained",
            wb_q.size() + rq_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule